// File: doc/BRIEF.md
# Serial Port FIFO and Interrupt Status Unit

This unit sits between a processor bus and the shift logic of a serial port. Bytes written by software queue in an 8-entry transmit FIFO, which a transmitter drains one byte at a time through a pop strobe. Bytes from a receiver enter a 16-entry receive FIFO through a push strobe. Each stored byte keeps its own break, framing and parity flags, plus an overrun flag. Software reads bytes from the head of the receive FIFO. The head entry's flags and the fill count appear in a status word.

Three sticky status bits record interrupt events: receive level reached, transmit space available, and receive timeout. Software clears one of them by writing zero to it. Each bit has its own enable, and a single interrupt line is the OR of the enabled bits. A small state machine runs a soft reset of fixed length that software starts through the control register. The FIFO flush bits act only when the flush-enable bit is set in the same write.

Top module: `uart_bufirq`

## Requirements
- R1: The receive FIFO holds 16 entries. Status bits [4:0] give the count of stored entries, and status bit 5 is 1 exactly when that count is zero. A read of select 4 (receive data) returns the oldest entry and removes it: data in bits [7:0], flags in bits [11:8].
- R2: The transmit FIFO holds 8 entries, and each write to select 3 appends bits [7:0]. A write while the FIFO holds 8 entries is dropped. `tx_avail` is 1 while the FIFO is non-empty, and `tx_byte` shows the oldest byte. A `tx_pop` strobe removes the oldest byte.
- R3: Control bits [5:4] select the receive trigger level: code 0 is 1 byte, code 1 is 4, code 2 is 8 and code 3 is 12. The receive status bit (status bit 6) becomes 1 on the clock after the receive count is at or above that level.
- R4: Control bits [7:6] select the transmit trigger in free entries: code 0 is 1, code 1 is 4, codes 2 and 3 are 8, which means the FIFO is empty. The transmit status bit (status bit 7) becomes 1 on the clock after the free space is at or above that level.
- R5: Status bits 6, 7 and 8 are sticky. A write to select 2 clears each of those bits written as 0 and leaves each one written as 1 unchanged. A set condition in the same clock wins over the clear.
- R6: Select 1 holds the enables: bit 0 for receive, bit 1 for transmit, bit 2 for timeout. `irq` is 1 exactly when some sticky status bit and its enable are both 1. With the transmit enable at 0, the transmit status bit never raises `irq`.
- R7: `rx_err` bit 0 is break, bit 1 is framing error and bit 2 is parity error. They are stored with the byte in entry bits 8, 9 and 10. Status bits 9, 10 and 11 show those flags for the head entry, and read as 0 when the FIFO is empty.
- R8: A push while the receive FIFO is full and not being read drops the new byte. It also sets the overrun flag (entry bit 11, status bit 12 at the head) on the newest stored entry.
- R9: Select 5 holds a timeout limit in character ticks. Each `char_tick` adds one to a timer while the receive FIFO is non-empty and has no push, pop or flush; any of those, or an empty FIFO, zeroes the timer. With a non-zero limit, status bit 8 becomes 1 on the clock after the timer has reached the limit.
- R10: Writing control bit 15 as 1 starts a soft reset that lasts SRST_CYCLES clocks. During it, control bit 15 reads 1 and bus writes, reads that would pop and line strobes have no effect. When it ends, the FIFOs, sticky bits, enables, trigger fields and timeout limit are all zero and bit 15 reads 0.
- R11: A control write flushes the receive FIFO only when bit 0 (flush enable) and bit 1 are both 1, and flushes the transmit FIFO only when bit 0 and bit 2 are both 1. With bit 0 at 0 the FIFO contents are kept.
- R12: Status bit 13 is 1 exactly when the transmit FIFO is empty and `tx_idle` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 3 | Register select: 0 control, 1 enables, 2 status, 3 transmit data, 4 receive data, 5 timeout limit |
| bus_we | input | 1 | Write strobe for one clock |
| bus_re | input | 1 | Read strobe for one clock (pops on select 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from select |
| irq | output | 1 | Interrupt request |
| rx_push | input | 1 | Receiver presents one byte |
| rx_byte | input | 8 | Received byte |
| rx_err | input | 3 | Received byte flags: break, framing, parity |
| tx_pop | input | 1 | Transmitter takes the head byte |
| tx_byte | output | 8 | Head byte of the transmit FIFO |
| tx_avail | output | 1 | Transmit FIFO non-empty |
| tx_idle | input | 1 | Transmit shifter idle |
| char_tick | input | 1 | One pulse per character time |

## Verification
FIFO counts, head data and `tx_avail` change at the clock edge that takes a strobe. Register writes take effect at the edge after the write is presented. The sticky bits use the fill levels from before that edge, so a status bit rises one clock after the level change, two clocks after the push or pop that caused it. `irq` follows a sticky bit or an enable in the same cycle, because it is a combinational AND-OR. The soft reset holds the busy flag for SRST_CYCLES edges after the write edge. The bench drives inputs after the falling edge and updates its queue model at each rising edge. It compares the status word, `irq` and the transmit head two nanoseconds after every falling edge, which also checks every one of these latencies to the cycle.

// File: rtl/ubi_pkg.sv
package ubi_pkg;

    // register selects
    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_IEN  = 3'd1;
    localparam logic [2:0] SEL_STAT = 3'd2;
    localparam logic [2:0] SEL_TXD  = 3'd3;
    localparam logic [2:0] SEL_RXD  = 3'd4;
    localparam logic [2:0] SEL_TOUT = 3'd5;

    // control bits
    localparam int CB_FLUSH_EN = 0;
    localparam int CB_RX_FLUSH = 1;
    localparam int CB_TX_FLUSH = 2;
    localparam int CB_RX_TRIG  = 4;
    localparam int CB_TX_TRIG  = 6;
    localparam int CB_SRST     = 15;

    // status bits (count field occupies [4:0])
    localparam int SB_RX_NONE  = 5;
    localparam int SB_STICKY   = 6;   // three sticky bits: rx, tx, timeout
    localparam int SB_FLAGS    = 9;   // four head flags: brk, fe, pe, ovr
    localparam int SB_TX_DONE  = 13;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_SRST = 1'b1
    } srst_state_e;

    typedef struct packed {
        logic       ovr;
        logic       pe;
        logic       fe;
        logic       brk;
        logic [7:0] data;
    } rx_entry_t;

    function automatic int unsigned rx_level(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 12;
        endcase
    endfunction

    function automatic int unsigned tx_level(input logic [1:0] code, input int unsigned depth);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            default: return depth;
        endcase
    endfunction

endpackage

// File: rtl/ubi_fifo.sv
module ubi_fifo #(
    parameter int unsigned WIDTH    = 8,
    parameter int unsigned DEPTH    = 8,
    parameter bit          HAS_MARK = 1'b0,
    localparam int unsigned AW      = $clog2(DEPTH),
    localparam int unsigned CW      = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic             mark,
    input  logic [WIDTH-1:0] mark_bits,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             empty,
    output logic             full
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_ptr;
    logic [AW-1:0]    wr_ptr;
    logic             do_pop;
    logic             do_push;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_pop)
                rd_ptr <= rd_ptr + AW'(1);
            if (do_push)
                wr_ptr <= wr_ptr + AW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    generate
        if (HAS_MARK) begin : g_mark
            always_ff @(posedge clk) begin
                if (!clr && do_push)
                    mem[wr_ptr] <= din;
                else if (!clr && mark && !empty)
                    mem[wr_ptr - AW'(1)] <= mem[wr_ptr - AW'(1)] | mark_bits;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (!clr && do_push)
                    mem[wr_ptr] <= din;
            end
        end
    endgenerate

endmodule

// File: rtl/ubi_srst_fsm.sv
module ubi_srst_fsm
    import ubi_pkg::*;
#(
    parameter int unsigned CYCLES = 4,
    localparam int unsigned CNW   = $clog2(CYCLES) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    srst_state_e    state_q, state_d;
    logic [CNW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (start) begin
                    state_d = ST_SRST;
                    cnt_d   = CNW'(CYCLES - 1);
                end
            end
            ST_SRST: begin
                if (cnt_q == '0)
                    state_d = ST_RUN;
                else
                    cnt_d = cnt_q - CNW'(1);
            end
        endcase
    end

    always_comb begin
        busy = (state_q == ST_SRST);
    end

endmodule

// File: rtl/ubi_status.sv
module ubi_status #(
    parameter int unsigned RXCW     = 5,
    parameter int unsigned TXCW     = 4,
    parameter int unsigned TOW      = 8,
    parameter int unsigned TX_DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [RXCW-1:0] rx_count,
    input  logic [TXCW-1:0] tx_count,
    input  logic [RXCW-1:0] rx_lvl,
    input  logic [TXCW-1:0] tx_lvl,
    input  logic [TOW-1:0]  limit,
    input  logic            tick,
    input  logic            rx_act,
    input  logic            wr,
    input  logic [2:0]      wr_keep,
    output logic [2:0]      sticky
);

    logic [TOW-1:0] tcnt;
    logic [2:0]     set_now;
    logic [2:0]     keep;

    always_comb begin
        set_now[0] = (rx_count >= rx_lvl);
        set_now[1] = ((TXCW'(TX_DEPTH) - tx_count) >= tx_lvl);
        set_now[2] = (rx_count != '0) && (limit != '0) && (tcnt >= limit);
        keep       = wr ? wr_keep : 3'b111;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky <= '0;
            tcnt   <= '0;
        end else if (clr) begin
            sticky <= '0;
            tcnt   <= '0;
        end else begin
            sticky <= (sticky & keep) | set_now;
            if ((rx_count == '0) || rx_act)
                tcnt <= '0;
            else if (tick && (tcnt < limit))
                tcnt <= tcnt + TOW'(1);
        end
    end

endmodule

// File: rtl/uart_bufirq.sv
module uart_bufirq
    import ubi_pkg::*;
#(
    parameter int unsigned RX_DEPTH    = 16,
    parameter int unsigned TX_DEPTH    = 8,
    parameter int unsigned TOUT_W      = 8,
    parameter int unsigned SRST_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_sel,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    input  logic        rx_push,
    input  logic [7:0]  rx_byte,
    input  logic [2:0]  rx_err,
    input  logic        tx_pop,
    output logic [7:0]  tx_byte,
    output logic        tx_avail,
    input  logic        tx_idle,
    input  logic        char_tick
);

    localparam int unsigned RXCW = $clog2(RX_DEPTH) + 1;
    localparam int unsigned TXCW = $clog2(TX_DEPTH) + 1;
    localparam int unsigned EW   = $bits(rx_entry_t);

    logic            busy, live;
    logic            wr_ctrl, srst_req, cfg_wr, stat_wr;
    logic            rx_flush, tx_flush;
    logic            rx_pop_req, rx_pop_eff, rx_push_live, rx_push_ok, rx_mark, rx_act;
    logic            tx_push_req, tx_pop_req;
    logic [RXCW-1:0] rx_count;
    logic [TXCW-1:0] tx_count;
    logic            rx_empty, rx_full, tx_empty, tx_full;
    rx_entry_t       rx_head, rx_in;
    logic [7:0]      tx_head;
    logic [2:0]      sticky;
    logic [2:0]      ien_q;
    logic [1:0]      rxt_q, txt_q;
    logic [TOUT_W-1:0] limit_q;
    logic [RXCW-1:0] rx_lvl;
    logic [TXCW-1:0] tx_lvl;
    logic [31:0]     stat_word;
    logic [3:0]      head_flags;

    // ---------------- soft reset sequencer ----------------
    ubi_srst_fsm #(.CYCLES(SRST_CYCLES)) u_srst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (srst_req),
        .busy  (busy)
    );

    // ---------------- bus decode ----------------
    assign live     = !busy;
    assign wr_ctrl  = live && bus_we && (bus_sel == SEL_CTRL);
    assign srst_req = wr_ctrl && bus_wdata[CB_SRST];
    assign cfg_wr   = wr_ctrl && !bus_wdata[CB_SRST];
    assign rx_flush = cfg_wr && bus_wdata[CB_FLUSH_EN] && bus_wdata[CB_RX_FLUSH];
    assign tx_flush = cfg_wr && bus_wdata[CB_FLUSH_EN] && bus_wdata[CB_TX_FLUSH];
    assign stat_wr  = live && bus_we && (bus_sel == SEL_STAT);

    assign rx_pop_req   = live && bus_re && (bus_sel == SEL_RXD);
    assign rx_pop_eff   = rx_pop_req && !rx_empty;
    assign rx_push_live = live && rx_push;
    assign rx_push_ok   = rx_push_live && (!rx_full || rx_pop_eff);
    assign rx_mark      = rx_push_live && rx_full && !rx_pop_eff && !rx_flush;
    assign rx_act       = rx_push_ok || rx_pop_eff || rx_flush;

    assign tx_push_req = live && bus_we && (bus_sel == SEL_TXD);
    assign tx_pop_req  = live && tx_pop;

    // ---------------- configuration registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxt_q   <= '0;
            txt_q   <= '0;
            ien_q   <= '0;
            limit_q <= '0;
        end else if (busy) begin
            rxt_q   <= '0;
            txt_q   <= '0;
            ien_q   <= '0;
            limit_q <= '0;
        end else begin
            if (cfg_wr) begin
                rxt_q <= bus_wdata[CB_RX_TRIG +: 2];
                txt_q <= bus_wdata[CB_TX_TRIG +: 2];
            end
            if (bus_we && (bus_sel == SEL_IEN))
                ien_q <= bus_wdata[2:0];
            if (bus_we && (bus_sel == SEL_TOUT))
                limit_q <= bus_wdata[TOUT_W-1:0];
        end
    end

    assign rx_lvl = RXCW'(rx_level(rxt_q));
    assign tx_lvl = TXCW'(tx_level(txt_q, TX_DEPTH));

    // ---------------- FIFOs ----------------
    assign rx_in = '{ovr: 1'b0, pe: rx_err[2], fe: rx_err[1], brk: rx_err[0], data: rx_byte};

    ubi_fifo #(.WIDTH(EW), .DEPTH(RX_DEPTH), .HAS_MARK(1'b1)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (busy || rx_flush),
        .push      (rx_push_live),
        .pop       (rx_pop_req),
        .mark      (rx_mark),
        .mark_bits (EW'(1) << (EW - 1)),
        .din       (rx_in),
        .dout      (rx_head),
        .count     (rx_count),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    ubi_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH), .HAS_MARK(1'b0)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (busy || tx_flush),
        .push      (tx_push_req),
        .pop       (tx_pop_req),
        .mark      (1'b0),
        .mark_bits (8'h00),
        .din       (bus_wdata[7:0]),
        .dout      (tx_head),
        .count     (tx_count),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    assign tx_byte  = tx_head;
    assign tx_avail = !tx_empty;

    // ---------------- sticky status and timeout ----------------
    ubi_status #(.RXCW(RXCW), .TXCW(TXCW), .TOW(TOUT_W), .TX_DEPTH(TX_DEPTH)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (busy),
        .rx_count (rx_count),
        .tx_count (tx_count),
        .rx_lvl   (rx_lvl),
        .tx_lvl   (tx_lvl),
        .limit    (limit_q),
        .tick     (char_tick),
        .rx_act   (rx_act),
        .wr       (stat_wr),
        .wr_keep  (bus_wdata[SB_STICKY +: 3]),
        .sticky   (sticky)
    );

    assign irq = |(sticky & ien_q);

    // ---------------- read path ----------------
    assign head_flags = rx_empty ? 4'h0 : {rx_head.ovr, rx_head.pe, rx_head.fe, rx_head.brk};

    always_comb begin
        stat_word                  = '0;
        stat_word[4:0]             = 5'(rx_count);
        stat_word[SB_RX_NONE]      = rx_empty;
        stat_word[SB_STICKY +: 3]  = sticky;
        stat_word[SB_FLAGS +: 4]   = head_flags;
        stat_word[SB_TX_DONE]      = tx_empty && tx_idle;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_sel)
            SEL_CTRL: begin
                bus_rdata[CB_SRST]         = busy;
                bus_rdata[CB_RX_TRIG +: 2] = rxt_q;
                bus_rdata[CB_TX_TRIG +: 2] = txt_q;
            end
            SEL_IEN:  bus_rdata[2:0] = ien_q;
            SEL_STAT: bus_rdata = stat_word;
            SEL_RXD:  bus_rdata[EW-1:0] = rx_empty ? '0 : rx_head;
            SEL_TOUT: bus_rdata[TOUT_W-1:0] = limit_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ubi_checker.sv
module ubi_checker #(
    parameter int unsigned RX_DEPTH = 16,
    parameter int unsigned RXCW     = 5,
    parameter int unsigned TXCW     = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            stat_wr,
    input logic            cfg_wr,
    input logic [31:0]     bus_wdata,
    input logic [RXCW-1:0] rx_count,
    input logic [TXCW-1:0] tx_count,
    input logic [RXCW-1:0] rx_lvl,
    input logic [2:0]      sticky,
    input logic [2:0]      ien_q,
    input logic            irq,
    input logic            rx_full,
    input logic            rx_push_live,
    input logic            rx_pop_eff,
    input logic            rx_flush,
    input logic            rx_act
);

    // R1: fill count never exceeds the depth
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= RXCW'(RX_DEPTH));

    // R5: a write of 0 clears the receive bit when its level is not met
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !bus_wdata[6] && (rx_count < rx_lvl)) |=> !sticky[0]);

    // R5: the receive bit holds unless cleared or reset
    a_r5_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky[0] && !busy && !(stat_wr && !bus_wdata[6])) |=> sticky[0]);

    // R6: no enable, no interrupt
    a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == 3'b000) |-> !irq);

    // R8: a push into a full FIFO with no read keeps it full, no growth
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rx_push_live && !rx_pop_eff && !rx_flush) |=> (rx_count == RXCW'(RX_DEPTH)));

    // R11: without flush enable the receive count is kept
    a_r11_flush_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !bus_wdata[0] && !rx_act) |=> (rx_count == $past(rx_count)));

    // R10: when the soft reset ends the state is cleared
    a_r10_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ((rx_count == '0) && (tx_count == '0) && (ien_q == 3'b000) && (sticky == 3'b000)));

endmodule

bind uart_bufirq ubi_checker #(
    .RX_DEPTH (RX_DEPTH),
    .RXCW     (RXCW),
    .TXCW     (TXCW)
) u_ubi_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .stat_wr      (stat_wr),
    .cfg_wr       (cfg_wr),
    .bus_wdata    (bus_wdata),
    .rx_count     (rx_count),
    .tx_count     (tx_count),
    .rx_lvl       (rx_lvl),
    .sticky       (sticky),
    .ien_q        (ien_q),
    .irq          (irq),
    .rx_full      (rx_full),
    .rx_push_live (rx_push_live),
    .rx_pop_eff   (rx_pop_eff),
    .rx_flush     (rx_flush),
    .rx_act       (rx_act)
);

// File: tb/test_uart_bufirq.sv
`timescale 1ns/1ps
module test_uart_bufirq;

    localparam int SRST = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_sel = 3'd2;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [2:0]  rx_err = '0;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_avail;
    logic        tx_idle = 1'b1;
    logic        char_tick = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    uart_bufirq #(.SRST_CYCLES(SRST)) i_uart_bufirq (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .rx_push(rx_push), .rx_byte(rx_byte), .rx_err(rx_err),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .tx_avail(tx_avail),
        .tx_idle(tx_idle), .char_tick(char_tick)
    );

    // ---------------- behavioural reference ----------------
    logic [11:0] rxq[$];
    logic [7:0]  txq[$];
    logic [2:0]  m_st, m_ien;
    logic [1:0]  m_rxt, m_txt;
    int          m_lim, m_tcnt, m_scnt;
    bit          m_busy;

    function automatic int rx_lv(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 4 : (c == 2'd2) ? 8 : 12;
    endfunction
    function automatic int tx_lv(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 4 : 8;
    endfunction

    task automatic m_clear();
        rxq.delete(); txq.delete();
        m_st = 0; m_ien = 0; m_rxt = 0; m_txt = 0; m_lim = 0; m_tcnt = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_clear(); m_busy = 0; m_scnt = 0;
        end else if (m_busy) begin
            m_clear();
            if (m_scnt == 0) m_busy = 0; else m_scnt--;
        end else begin
            int  rxn, txn;
            bit  srx, stx, sto, wctl, srq, cfg, rxfl, txfl, rpop, rpush, tpop, tpush;
            logic [2:0] keep;
            rxn = rxq.size(); txn = txq.size();
            srx = rxn >= rx_lv(m_rxt);
            stx = (8 - txn) >= tx_lv(m_txt);
            sto = (rxn != 0) && (m_lim != 0) && (m_tcnt >= m_lim);
            keep = (bus_we && bus_sel == 3'd2) ? bus_wdata[8:6] : 3'b111;
            m_st = (m_st & keep) | {sto, stx, srx};
            wctl = bus_we && bus_sel == 3'd0;
            srq  = wctl && bus_wdata[15];
            cfg  = wctl && !bus_wdata[15];
            rxfl = cfg && bus_wdata[0] && bus_wdata[1];
            txfl = cfg && bus_wdata[0] && bus_wdata[2];
            rpop = bus_re && bus_sel == 3'd4 && rxn > 0;
            rpush = rx_push && (rxn < 16 || rpop);
            if (rxn == 0 || rpush || rpop || rxfl) m_tcnt = 0;
            else if (char_tick && m_tcnt < m_lim) m_tcnt++;
            if (rxfl) rxq.delete();
            else begin
                if (rpop) void'(rxq.pop_front());
                if (rpush) rxq.push_back({1'b0, rx_err, rx_byte});
                else if (rx_push) rxq[rxq.size()-1] = rxq[rxq.size()-1] | 12'h800;
            end
            tpop  = tx_pop && txn > 0;
            tpush = bus_we && bus_sel == 3'd3 && (txn < 8 || tpop);
            if (txfl) txq.delete();
            else begin
                if (tpop) void'(txq.pop_front());
                if (tpush) txq.push_back(bus_wdata[7:0]);
            end
            if (cfg) begin m_rxt = bus_wdata[5:4]; m_txt = bus_wdata[7:6]; end
            if (srq) begin m_busy = 1; m_scnt = SRST - 1; end
            if (bus_we && bus_sel == 3'd1) m_ien = bus_wdata[2:0];
            if (bus_we && bus_sel == 3'd5) m_lim = int'(bus_wdata[7:0]);
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            logic [31:0] e;
            e = '0;
            e[4:0] = 5'(rxq.size());
            e[5]   = (rxq.size() == 0);
            e[8:6] = m_st;
            if (rxq.size() > 0) e[12:9] = rxq[0][11:8];
            e[13]  = (txq.size() == 0) && tx_idle;
            if (bus_sel == 3'd2) begin
                chk(bus_rdata[5:0] == e[5:0], "R1 count/empty", bus_rdata[5:0], e[5:0]);
                chk(bus_rdata[6] == e[6], "R3 rx status", bus_rdata[6], e[6]);
                chk(bus_rdata[7] == e[7], "R4 tx status", bus_rdata[7], e[7]);
                chk(bus_rdata[8] == e[8], "R9 timeout status", bus_rdata[8], e[8]);
                chk(bus_rdata[11:9] == e[11:9], "R7 head flags", bus_rdata[11:9], e[11:9]);
                chk(bus_rdata[12] == e[12], "R8 head overrun", bus_rdata[12], e[12]);
                chk(bus_rdata[13] == e[13], "R12 all sent", bus_rdata[13], e[13]);
            end
            chk(irq == |(m_st & m_ien), "R6 irq", irq, |(m_st & m_ien));
            chk(tx_avail == (txq.size() > 0), "R2 tx_avail", tx_avail, txq.size() > 0);
            if (txq.size() > 0) chk(tx_byte == txq[0], "R2 tx_byte", tx_byte, txq[0]);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk); bus_sel = s; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0; bus_sel = 3'd2;
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] v);
        @(negedge clk); bus_sel = s; bus_re = 1'b1; #2; v = bus_rdata;
        @(negedge clk); bus_re = 1'b0; bus_sel = 3'd2;
    endtask

    task automatic peek(input logic [2:0] s, output logic [31:0] v);
        @(negedge clk); bus_sel = s; #2; v = bus_rdata;
        @(negedge clk); bus_sel = 3'd2;
    endtask

    task automatic rx_in(input logic [7:0] b, input logic [2:0] e);
        @(negedge clk); rx_push = 1'b1; rx_byte = b; rx_err = e;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic txp();
        @(negedge clk); tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); char_tick = 1'b1;
        @(negedge clk); char_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_errors++; n_checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        idle(3); rst_n = 1'b1; idle(3);

        // reset state
        peek(3'd2, v); chk(v == 32'h20A0, "R1 reset status", v, 32'h20A0);

        // ordering and per-character flags
        rx_in(8'h41, 3'b000); rx_in(8'h42, 3'b001); rx_in(8'h43, 3'b100); idle(2);
        peek(3'd2, v); chk(v[4:0] == 5'd3, "R1 count three", v[4:0], 3);
        rd(3'd4, v); chk(v[11:0] == 12'h041, "R1 oldest first", v[11:0], 12'h041);
        peek(3'd2, v); chk(v[12:9] == 4'h1, "R7 break flag at head", v[12:9], 1);
        rd(3'd4, v); chk(v[11:0] == 12'h142, "R7 break stored", v[11:0], 12'h142);
        rd(3'd4, v); chk(v[11:0] == 12'h443, "R7 parity stored", v[11:0], 12'h443);

        // write-zero clear, write-one keep
        wr(3'd2, 32'h180); idle(1);
        peek(3'd2, v); chk(v[6] == 1'b0, "R5 write 0 clears", v[6], 0);
        chk(v[7] == 1'b1, "R5 write 1 keeps", v[7], 1);

        // receive trigger level 4
        wr(3'd0, 32'h10);
        rx_in(8'h01, 0); rx_in(8'h02, 0); rx_in(8'h03, 0);
        wr(3'd2, 32'h180); idle(2);
        peek(3'd2, v); chk(v[6] == 1'b0, "R3 below level 4", v[6], 0);
        rx_in(8'h04, 0); idle(2);
        peek(3'd2, v); chk(v[6] == 1'b1, "R3 at level 4", v[6], 1);
        wr(3'd1, 32'h1); idle(1); chk(irq == 1'b1, "R6 rx enabled irq", irq, 1);
        wr(3'd1, 32'h0); idle(1); chk(irq == 1'b0, "R6 tx status not enabled", irq, 0);

        // flush gating
        wr(3'd0, 32'h12); idle(1);
        peek(3'd2, v); chk(v[4:0] == 5'd4, "R11 flush without enable", v[4:0], 4);
        wr(3'd0, 32'h13); idle(1);
        peek(3'd2, v); chk(v[4:0] == 5'd0, "R11 flush with enable", v[4:0], 0);

        // transmit FIFO capacity and order
        for (int i = 0; i < 9; i++) wr(3'd3, 32'h10 + i);
        peek(3'd2, v); chk(v[13] == 1'b0, "R12 not sent with data", v[13], 0);
        for (int i = 0; i < 8; i++) begin
            idle(1);
            chk(tx_byte == 8'(8'h10 + i), "R2 tx order", tx_byte, 8'h10 + i);
            txp();
        end
        idle(1); chk(tx_avail == 1'b0, "R2 ninth write dropped", tx_avail, 0);

        // transmit trigger: empty
        wr(3'd0, 32'h80); wr(3'd3, 32'hAA);
        wr(3'd2, 32'h140); idle(2);
        peek(3'd2, v); chk(v[7] == 1'b0, "R4 seven free below eight", v[7], 0);
        txp(); idle(2);
        peek(3'd2, v); chk(v[7] == 1'b1, "R4 empty reaches level", v[7], 1);

        // all sent requires idle shifter
        tx_idle = 1'b0; idle(1);
        peek(3'd2, v); chk(v[13] == 1'b0, "R12 shifter busy", v[13], 0);
        tx_idle = 1'b1; idle(1);
        peek(3'd2, v); chk(v[13] == 1'b1, "R12 shifter idle", v[13], 1);

        // overrun on full receive FIFO
        wr(3'd0, 32'h0);
        for (int i = 0; i < 16; i++) rx_in(8'(8'h60 + i), 0);
        rx_in(8'hEE, 0); idle(2);
        peek(3'd2, v); chk(v[4:0] == 5'd16, "R8 count stays 16", v[4:0], 16);
        for (int i = 0; i < 15; i++) begin
            rd(3'd4, v);
            chk(v[11:0] == 12'(8'h60 + i), "R8 stored data", v[11:0], 8'h60 + i);
        end
        rd(3'd4, v); chk(v[11:0] == 12'h86F, "R8 overrun on newest", v[11:0], 12'h86F);

        // timeout
        wr(3'd5, 32'd3); rx_in(8'h55, 0);
        tick(); tick(); idle(2);
        peek(3'd2, v); chk(v[8] == 1'b0, "R9 two ticks", v[8], 0);
        tick(); idle(2);
        peek(3'd2, v); chk(v[8] == 1'b1, "R9 limit reached", v[8], 1);
        wr(3'd1, 32'h4); idle(1); chk(irq == 1'b1, "R9 timeout irq", irq, 1);

        // soft reset
        wr(3'd1, 32'h7); wr(3'd0, 32'h8000);
        peek(3'd0, v); chk(v[15] == 1'b1, "R10 busy readback", v[15], 1);
        idle(SRST + 2);
        peek(3'd0, v); chk(v == 32'h0, "R10 self clear", v, 0);
        peek(3'd1, v); chk(v == 32'h0, "R10 enables cleared", v, 0);
        peek(3'd5, v); chk(v == 32'h0, "R10 limit cleared", v, 0);
        peek(3'd2, v); chk(v[5:0] == 6'h20, "R10 receive emptied", v[5:0], 6'h20);
        idle(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule